// File: doc/BRIEF.md
# Sparse Parallel Prefix Integer Adder

This block is a combinational adder for two unsigned operands of width `N` with a carry input and a carry output. Each bit position forms its own generate, propagate and half-sum signals. A prefix network then works out carries only at the edges of the 4-bit groups, and it needs about log2(N/4) operator levels to do so. Each 4-bit group is a carry-select block. It builds one local sum that assumes an incoming carry of 0 and a second that assumes an incoming carry of 1. The boundary carry from the prefix network picks one of the two.

A datapath uses it wherever a wide single-cycle add is wanted at lower wiring cost than a dense prefix adder. Sparse carry computation keeps the prefix tree N/4 wide rather than N wide. The ripple work that remains is local to each group and runs in parallel with the tree.

Top module: `spa_adder`

## Requirements
- R1: The width `N` is a parameter with a default of 16. A width that is not a multiple of 4 stops elaboration.
- R2: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^N for every input combination.
- R3: `cout_o` is 1 exactly when `a_i` + `b_i` + `cin_i` is at least 2^N.
- R4: With `cin_i` = 1 the result is one greater than the result for the same operands with `cin_i` = 0.
- R5: A carry that enters at bit 0 propagates across every group boundary. All-ones plus zero with `cin_i` = 1 gives `sum_o` = 0 and `cout_o` = 1.
- R6: A carry produced at the top of one 4-bit group enters the next group. For example, 0x000F + 0x0001 gives 0x0010.
- R7: The block holds no state. Outputs depend only on the present inputs and are valid in the same cycle in which the inputs are applied.
- R8: The result is correct at widths 8, 16 and 32, which use one, two and three prefix levels respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Low N bits of the sum |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The embedded checks assume that the operands and the carry input are fully driven, known values. Each check compares the sparse prefix carries against a group-by-group ripple of the same group signals. The stimulus keeps within that assumption by driving every input explicitly before the outputs are sampled. It sweeps the 8-bit instance over every operand pair with both carry values. The 16-bit and 32-bit instances receive all-ones and all-zeros corners, group-boundary carries and pseudo-random operands.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int unsigned GRP_W = 4;

  function automatic int unsigned prefix_levels(input int unsigned groups);
    return (groups > 1) ? $clog2(groups) : 0;
  endfunction
endpackage

// File: rtl/spa_sparse_tree.sv
module spa_sparse_tree
  import spa_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         gen_i,
  input  logic [N-1:0]         prop_i,
  input  logic                 cin_i,
  output logic [N/GRP_W-1:0]   gcarry_o,
  output logic                 cout_o
);
  localparam int unsigned NG = N / GRP_W;
  localparam int unsigned LV = prefix_levels(NG);

  logic [NG-1:0]        grp_g;
  logic [NG-1:0]        grp_p;
  logic [LV:0][NG-1:0]  lvl_g;
  logic [LV:0][NG-1:0]  lvl_p;

  // group generate / propagate over each 4-bit slice
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      logic tg;
      logic tp;
      tg = 1'b0;
      tp = 1'b1;
      for (int j = 0; j < GRP_W; j++) begin
        tg = gen_i[k*GRP_W+j] | (prop_i[k*GRP_W+j] & tg);
        tp = tp & prop_i[k*GRP_W+j];
      end
      grp_g[k] = tg;
      grp_p[k] = tp;
    end
  end

  // level 0: carry-in folded into the lowest group
  always_comb begin
    lvl_g[0]    = grp_g;
    lvl_p[0]    = grp_p;
    lvl_g[0][0] = grp_g[0] | (grp_p[0] & cin_i);
  end

  // Kogge-Stone levels of black operators over the group signals
  genvar l, i;
  generate
    for (l = 1; l <= LV; l++) begin : g_lvl
      localparam int unsigned D = 1 << (l - 1);
      for (i = 0; i < NG; i++) begin : g_node
        if (i >= D) begin : g_black
          assign lvl_g[l][i] = lvl_g[l-1][i] | (lvl_p[l-1][i] & lvl_g[l-1][i-D]);
          assign lvl_p[l][i] = lvl_p[l-1][i] & lvl_p[l-1][i-D];
        end else begin : g_pass
          assign lvl_g[l][i] = lvl_g[l-1][i];
          assign lvl_p[l][i] = lvl_p[l-1][i];
        end
      end
    end
  endgenerate

  always_comb begin
    gcarry_o[0] = cin_i;
    for (int k = 1; k < NG; k++) gcarry_o[k] = lvl_g[LV][k-1];
    cout_o = lvl_g[LV][NG-1];
  end

  // prefix carries must agree with a group-level ripple of the same signals
  always_comb begin
    for (int k = 0; k + 1 < NG; k++) begin
      AST_GRP_RIPPLE: assert (gcarry_o[k+1] == (grp_g[k] | (grp_p[k] & gcarry_o[k]))); // R6
    end
    AST_TOP_RIPPLE: assert (cout_o == (grp_g[NG-1] | (grp_p[NG-1] & gcarry_o[NG-1]))); // R3
  end
endmodule

// File: rtl/spa_csel_group.sv
module spa_csel_group
  import spa_pkg::*;
(
  input  logic [GRP_W-1:0] gen_i,
  input  logic [GRP_W-1:0] prop_i,
  input  logic [GRP_W-1:0] half_i,
  input  logic             sel_i,
  output logic [GRP_W-1:0] sum_o
);
  logic [GRP_W:0] c_zero;
  logic [GRP_W:0] c_one;

  always_comb begin
    c_zero[0] = 1'b0;
    c_one[0]  = 1'b1;
    for (int j = 0; j < GRP_W; j++) begin
      c_zero[j+1] = gen_i[j] | (prop_i[j] & c_zero[j]);
      c_one[j+1]  = gen_i[j] | (prop_i[j] & c_one[j]);
    end
  end

  assign sum_o = sel_i ? (half_i ^ c_one[GRP_W-1:0]) : (half_i ^ c_zero[GRP_W-1:0]);

  // the carry-in-one chain can never carry less than the carry-in-zero chain
  always_comb begin
    AST_CAND_MONO: assert (!c_zero[GRP_W] || c_one[GRP_W]); // R4
  end
endmodule

// File: rtl/spa_adder.sv
module spa_adder
  import spa_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG = N / GRP_W;

  generate
    if ((N % GRP_W) != 0 || N == 0) begin : g_bad_width
      $error("spa_adder: N must be a non-zero multiple of 4"); // R1
    end
  endgenerate

  logic [N-1:0]  bit_g;
  logic [N-1:0]  bit_p;
  logic [N-1:0]  bit_h;
  logic [NG-1:0] grp_cin;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;
  assign bit_h = a_i ^ b_i;

  spa_sparse_tree #(.N(N)) u_tree (
    .gen_i    (bit_g),
    .prop_i   (bit_p),
    .cin_i    (cin_i),
    .gcarry_o (grp_cin),
    .cout_o   (cout_o)
  );

  genvar k;
  generate
    for (k = 0; k < NG; k++) begin : g_grp
      spa_csel_group u_grp (
        .gen_i  (bit_g[k*GRP_W +: GRP_W]),
        .prop_i (bit_p[k*GRP_W +: GRP_W]),
        .half_i (bit_h[k*GRP_W +: GRP_W]),
        .sel_i  (grp_cin[k]),
        .sum_o  (sum_o[k*GRP_W +: GRP_W])
      );
    end
  endgenerate

  always_comb begin
    AST_SUM_EXACT: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i})); // R2
    AST_FULL_PROP: assert (!((&bit_h) && cin_i) || (sum_o == '0 && cout_o)); // R5
  end
endmodule

// File: tb/spa_adder_bench.sv
module spa_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  a8  = '0, b8  = '0, s8;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic c8 = 1'b0, c16 = 1'b0, c32 = 1'b0;
  logic co8, co16, co32;

  spa_adder #(.N(8))  u_spa_adder_n8  (.a_i(a8),  .b_i(b8),  .cin_i(c8),  .sum_o(s8),  .cout_o(co8));
  spa_adder #(.N(16)) u_spa_adder     (.a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
  spa_adder #(.N(32)) u_spa_adder_n32 (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [63:0] exp;
    @(posedge clk);
    a16 = a; b16 = b; c16 = c;
    exp = 64'(a) + 64'(b) + 64'(c);
    @(negedge clk);
    check(req, {47'b0, co16, s16}, exp);
  endtask

  task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
    logic [63:0] exp;
    @(posedge clk);
    a32 = a; b32 = b; c32 = c;
    exp = 64'(a) + 64'(b) + 64'(c);
    @(negedge clk);
    check(req, {31'b0, co32, s32}, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [63:0] r0, r1;
    // R7 reset-free state: all-zero inputs give zero outputs
    @(negedge clk);
    check("R7 idle n16", {47'b0, co16, s16}, 64'd0);
    check("R7 idle n32", {31'b0, co32, s32}, 64'd0);

    // R8 R2 R3: exhaustive sweep of the 8-bit instance
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a8 = 8'(a); b8 = 8'(b); c8 = 1'(c);
          @(negedge clk);
          check("R8 R2 R3 n8", {55'b0, co8, s8}, 64'(a + b + c));
        end
      end
    end

    // R5: full-length propagation
    run16("R5 n16 ones+0+1", 16'hFFFF, 16'h0000, 1'b1);
    run32("R5 n32 ones+0+1", 32'hFFFF_FFFF, 32'h0, 1'b1);
    run16("R5 n16 ones+ones+1", 16'hFFFF, 16'hFFFF, 1'b1);
    run32("R3 n32 zeros", 32'h0, 32'h0, 1'b0);
    run32("R5 n32 alt+alt+1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);

    // R6: carries crossing single group boundaries
    run16("R6 n16 boundary0", 16'h000F, 16'h0001, 1'b0);
    run16("R6 n16 boundary1", 16'h00F0, 16'h0010, 1'b0);
    run32("R6 n32 boundary6", 32'h0F00_0000, 32'h0100_0000, 1'b0);
    run16("R6 n16 cin ripple", 16'h0FFF, 16'h0000, 1'b1);

    // R4: carry-in adds one
    for (int n = 0; n < 200; n++) begin
      logic [15:0] a, b;
      a = 16'($urandom); b = 16'($urandom);
      @(posedge clk); a16 = a; b16 = b; c16 = 1'b0;
      @(negedge clk); r0 = {47'b0, co16, s16};
      @(posedge clk); c16 = 1'b1;
      @(negedge clk); r1 = {47'b0, co16, s16};
      check("R4 n16 cin step", r1, r0 + 64'd1);
    end

    // R2 R3 R8: random vectors at 16 and 32 bits
    for (int n = 0; n < 2000; n++) begin
      run16("R2 R3 n16 random", 16'($urandom), 16'($urandom), 1'($urandom));
      run32("R2 R3 n32 random", $urandom, $urandom, 1'($urandom));
    end

    // R1: default width is 16
    check("R1 default width", 64'($bits(u_spa_adder.sum_o)), 64'd16);

    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end
endmodule